// File: doc/BRIEF.md
# Register-Mapped Serial Port with Queued Transmit and Receive

This block is a serial port that a processor drives over a simple 32-bit register bus. Bytes written to the send register go into an eight-entry queue. A transmitter shifts each byte out as one start bit, eight data bits sent least significant bit first, and one stop bit. A receiver rebuilds bytes from the input pin and places them in a second eight-entry queue.

Each data register carries its own queue status in bit 31. Software can therefore poll and move a byte in a single access: one write to send, or one read to receive. Transmit and receive have separate enable bits. A programmable divisor sets the line rate. A pending flag, gated by an enable mask, drives one interrupt output when received data is waiting.

The divisor produces a 16x oversample tick every (divisor + 1) clocks. One serial bit therefore lasts 16 × (divisor + 1) clocks. The receiver takes each bit at its midpoint. Read data is combinational on the bus cycle in which the read strobe is high, and a receive read takes its entry off the queue at the clock edge that ends that cycle.

Top module: `uart_mmio`

## Requirements
- R1: After reset, the transmit control, receive control, interrupt enable and divisor registers all read 0. The send register reads 0, the receive register reads 0x8000_0000, the serial output is high and the interrupt output is low.
- R2: Register offsets are: send 0x00, receive 0x04, transmit control 0x08, receive control 0x0C, interrupt enable 0x10, pending 0x14, divisor 0x18. The control registers read back only bit 0, the interrupt enable register reads back bits [1:0], and the divisor reads back in full.
- R3: A write to offset 0x00 queues wr_data[7:0] and ignores the upper bits. With the transmitter enabled, the byte goes out as a low start bit, the eight data bits least significant first, and a high stop bit. Each bit lasts 16 × (divisor + 1) clocks.
- R4: The send queue holds 8 bytes. While it is full, reading offset 0x00 returns bit 31 set, and a further write is dropped. Queued bytes leave in the order they were written.
- R5: While bit 0 of transmit control is 0, the serial output stays high, even when bytes are queued.
- R6: With the receiver enabled, a well-formed frame on the input pin adds its byte to the receive queue. A read of offset 0x04 then returns the byte in bits [7:0] with bit 31 clear, and removes that byte from the queue.
- R7: A read of offset 0x04 while the receive queue is empty returns 0x8000_0000 and changes no state.
- R8: While bit 0 of receive control is 0, frames on the input pin are ignored.
- R9: Pending bit 1 (offset 0x14) is set while the receive queue holds at least one byte. The interrupt output is the OR over bits of (pending AND interrupt enable).
- R10: The receive queue holds 8 bytes. A frame that completes while the queue is full is discarded, and the stored bytes read back in arrival order.
- R11: A frame whose stop bit samples low is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe; a receive read removes one byte |
| bus_rdata | output | 32 | Read data, valid while bus_rd is high |
| ser_tx | output | 1 | Serial output, idles high |
| ser_rx | input | 1 | Serial input |
| irq | output | 1 | Interrupt request |

## Verification
The bench fills the send queue with the transmitter disabled and writes one byte past capacity. A design that accepted the ninth write, overwrote an entry, or let the line toggle while disabled would send a ninth frame, reorder the bytes, or show activity on the idle line.

On the receive side the bench sends nine frames into an eight-entry queue, reads the queue while it is empty, and sends frames with the receiver disabled and with a low stop bit. Each of those cases would show up as an extra, missing or shifted byte, or as a pending flag that never clears.

The first frame uses data 0xA5, so a design that reversed the bit order or used the wrong bit time would return a different byte.

// File: rtl/uart_pkg.sv
package uart_pkg;
  // Register byte offsets on the bus
  typedef enum logic [4:0] {
    REG_TXD  = 5'h00,
    REG_RXD  = 5'h04,
    REG_TXC  = 5'h08,
    REG_RXC  = 5'h0C,
    REG_IEN  = 5'h10,
    REG_PEND = 5'h14,
    REG_DIV  = 5'h18
  } reg_off_e;

  localparam int unsigned BYTE_W = 8;
  localparam int unsigned OVS    = 16;   // oversample ticks per bit
endpackage

// File: rtl/uart_fifo.sv
module uart_fifo #(
  parameter int unsigned WIDTH = 8,
  parameter int unsigned DEPTH = 8,
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] wdata,
  input  logic             pop,
  output logic [WIDTH-1:0] rdata,
  output logic             full,
  output logic             empty,
  output logic [CW-1:0]    count
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [PW-1:0]    wptr_q, wptr_d, rptr_q, rptr_d;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic             do_push, do_pop;

  assign full    = (cnt_q == CW'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign count   = cnt_q;
  assign rdata   = mem[rptr_q];
  assign do_push = push && !full;   // write to a full queue is dropped
  assign do_pop  = pop && !empty;

  always_comb begin
    wptr_d = wptr_q;
    rptr_d = rptr_q;
    cnt_d  = cnt_q;
    if (do_push) wptr_d = (wptr_q == PW'(DEPTH - 1)) ? '0 : wptr_q + 1'b1;
    if (do_pop)  rptr_d = (rptr_q == PW'(DEPTH - 1)) ? '0 : rptr_q + 1'b1;
    if (do_push && !do_pop) cnt_d = cnt_q + 1'b1;
    if (!do_push && do_pop) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
      cnt_q  <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wptr_q] <= wdata;
  end
endmodule

// File: rtl/uart_tx.sv
module uart_tx
  import uart_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              tick,
  input  logic              avail,
  input  logic [BYTE_W-1:0] byte_in,
  output logic              take,
  output logic              line
);
  localparam int unsigned SW = $clog2(OVS);
  localparam int unsigned FW = BYTE_W + 2;

  logic          busy_q, busy_d;
  logic [FW-1:0] frame_q, frame_d;
  logic [3:0]    bit_q, bit_d;
  logic [SW-1:0] sub_q, sub_d;

  always_comb begin
    busy_d  = busy_q;
    frame_d = frame_q;
    bit_d   = bit_q;
    sub_d   = sub_q;
    take    = 1'b0;
    if (!en) begin
      busy_d = 1'b0;
    end else if (!busy_q) begin
      if (avail) begin
        take    = 1'b1;
        busy_d  = 1'b1;
        frame_d = {1'b1, byte_in, 1'b0};
        bit_d   = '0;
        sub_d   = '0;
      end
    end else if (tick) begin
      if (sub_q == SW'(OVS - 1)) begin
        sub_d   = '0;
        frame_d = {1'b1, frame_q[FW-1:1]};
        if (bit_q == 4'(FW - 1)) busy_d = 1'b0;
        else                     bit_d  = bit_q + 1'b1;
      end else begin
        sub_d = sub_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      frame_q <= '1;
      bit_q   <= '0;
      sub_q   <= '0;
    end else begin
      busy_q  <= busy_d;
      frame_q <= frame_d;
      bit_q   <= bit_d;
      sub_q   <= sub_d;
    end
  end

  assign line = !(en && busy_q) || frame_q[0];
endmodule

// File: rtl/uart_rx.sv
module uart_rx
  import uart_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              tick,
  input  logic              pin,
  output logic              done,
  output logic [BYTE_W-1:0] byte_out
);
  localparam int unsigned SW = $clog2(OVS);
  typedef enum logic [1:0] {S_IDLE, S_START, S_DATA, S_STOP} rx_state_e;

  rx_state_e         st_q, st_d;
  logic [SW-1:0]     sub_q, sub_d;
  logic [2:0]        bit_q, bit_d;
  logic [BYTE_W-1:0] sh_q, sh_d;
  logic [1:0]        sync_q;
  logic              rxs;

  assign rxs      = sync_q[1];
  assign byte_out = sh_q;

  always_comb begin
    st_d  = st_q;
    sub_d = sub_q;
    bit_d = bit_q;
    sh_d  = sh_q;
    done  = 1'b0;
    if (!en) begin
      st_d = S_IDLE;
    end else begin
      unique case (st_q)
        S_IDLE: if (!rxs) begin
          st_d  = S_START;
          sub_d = '0;
        end
        S_START: if (tick) begin
          if (sub_q == SW'(OVS / 2 - 1)) begin
            sub_d = '0;
            bit_d = '0;
            st_d  = rxs ? S_IDLE : S_DATA;   // glitch rejection at mid start
          end else sub_d = sub_q + 1'b1;
        end
        S_DATA: if (tick) begin
          if (sub_q == SW'(OVS - 1)) begin
            sub_d = '0;
            sh_d  = {rxs, sh_q[BYTE_W-1:1]};
            if (bit_q == 3'(BYTE_W - 1)) st_d  = S_STOP;
            else                         bit_d = bit_q + 1'b1;
          end else sub_d = sub_q + 1'b1;
        end
        S_STOP: if (tick) begin
          if (sub_q == SW'(OVS - 1)) begin
            done = rxs;                      // low stop bit: frame dropped
            st_d = S_IDLE;
          end else sub_d = sub_q + 1'b1;
        end
        default: st_d = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      sub_q  <= '0;
      bit_q  <= '0;
      sh_q   <= '0;
      sync_q <= 2'b11;
    end else begin
      st_q   <= st_d;
      sub_q  <= sub_d;
      bit_q  <= bit_d;
      sh_q   <= sh_d;
      sync_q <= {sync_q[0], pin};
    end
  end
endmodule

// File: rtl/uart_mmio.sv
module uart_mmio
  import uart_pkg::*;
#(
  parameter int unsigned FIFO_DEPTH = 8,
  parameter int unsigned DIV_W      = 32,
  localparam int unsigned CW        = $clog2(FIFO_DEPTH + 1)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [4:0]  bus_addr,
  input  logic        bus_wr,
  input  logic [31:0] bus_wdata,
  input  logic        bus_rd,
  output logic [31:0] bus_rdata,
  output logic        ser_tx,
  input  logic        ser_rx,
  output logic        irq
);
  logic [1:0]        rst_sq;
  logic              rst_s;
  logic              txen_q, txen_d, rxen_q, rxen_d;
  logic [1:0]        ien_q, ien_d, pend;
  logic [DIV_W-1:0]  div_q, div_d, dcnt_q, dcnt_d;
  logic              tick;
  logic              tx_push, tx_take, tx_full, tx_empty;
  logic              rx_pop, rx_push, rx_full, rx_empty;
  logic [BYTE_W-1:0] tx_byte, rx_byte, rx_head;
  logic [CW-1:0]     tx_cnt, rx_cnt;

  // reset: asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sq <= 2'b00;
    else        rst_sq <= {rst_sq[0], 1'b1};
  end
  assign rst_s = rst_sq[1];

  // oversample tick every div+1 clocks
  assign tick   = (dcnt_q >= div_q);
  assign dcnt_d = tick ? '0 : dcnt_q + 1'b1;

  assign tx_push = bus_wr && (bus_addr == REG_TXD);
  assign rx_pop  = bus_rd && (bus_addr == REG_RXD);
  assign pend    = {!rx_empty, 1'b0};
  assign irq     = |(pend & ien_q);

  always_comb begin
    txen_d = txen_q;
    rxen_d = rxen_q;
    ien_d  = ien_q;
    div_d  = div_q;
    if (bus_wr) begin
      unique case (bus_addr)
        REG_TXC: txen_d = bus_wdata[0];
        REG_RXC: rxen_d = bus_wdata[0];
        REG_IEN: ien_d  = bus_wdata[1:0];
        REG_DIV: div_d  = bus_wdata[DIV_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      txen_q <= 1'b0;
      rxen_q <= 1'b0;
      ien_q  <= '0;
      div_q  <= '0;
      dcnt_q <= '0;
    end else begin
      txen_q <= txen_d;
      rxen_q <= rxen_d;
      ien_q  <= ien_d;
      div_q  <= div_d;
      dcnt_q <= dcnt_d;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      unique case (bus_addr)
        REG_TXD:  bus_rdata = {tx_full, 31'b0};
        REG_RXD:  bus_rdata = {rx_empty, 23'b0, rx_empty ? 8'h00 : rx_head};
        REG_TXC:  bus_rdata = {31'b0, txen_q};
        REG_RXC:  bus_rdata = {31'b0, rxen_q};
        REG_IEN:  bus_rdata = {30'b0, ien_q};
        REG_PEND: bus_rdata = {30'b0, pend};
        REG_DIV:  bus_rdata = 32'(div_q);
        default:  bus_rdata = '0;
      endcase
    end
  end

  uart_fifo #(.WIDTH(BYTE_W), .DEPTH(FIFO_DEPTH)) i_txq (
    .clk(clk), .rst_n(rst_s), .push(tx_push), .wdata(bus_wdata[BYTE_W-1:0]),
    .pop(tx_take), .rdata(tx_byte), .full(tx_full), .empty(tx_empty), .count(tx_cnt)
  );

  uart_fifo #(.WIDTH(BYTE_W), .DEPTH(FIFO_DEPTH)) i_rxq (
    .clk(clk), .rst_n(rst_s), .push(rx_push), .wdata(rx_byte),
    .pop(rx_pop), .rdata(rx_head), .full(rx_full), .empty(rx_empty), .count(rx_cnt)
  );

  uart_tx i_tx (
    .clk(clk), .rst_n(rst_s), .en(txen_q), .tick(tick), .avail(!tx_empty),
    .byte_in(tx_byte), .take(tx_take), .line(ser_tx)
  );

  uart_rx i_rx (
    .clk(clk), .rst_n(rst_s), .en(rxen_q), .tick(tick), .pin(ser_rx),
    .done(rx_push), .byte_out(rx_byte)
  );
endmodule

// File: rtl/uart_mmio_chk.sv
module uart_mmio_chk #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned CW    = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          txen,
  input logic          line,
  input logic          irq,
  input logic [1:0]    ien,
  input logic          rx_empty,
  input logic          rx_read,
  input logic          rx_push,
  input logic [CW-1:0] tx_cnt,
  input logic [CW-1:0] rx_cnt
);
  // R5
  txoff_line_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !txen |-> line);
  // R4
  tx_no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_cnt <= CW'(DEPTH));
  // R10
  rx_no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_cnt <= CW'(DEPTH));
  // R7
  rx_empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_read && rx_empty && !rx_push) |=> rx_empty);
  // R9
  irq_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ien[1] && !rx_empty) |-> irq);
  // R9
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (ien[1] && !rx_empty));
endmodule

bind uart_mmio uart_mmio_chk #(.DEPTH(FIFO_DEPTH), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_s), .txen(txen_q), .line(ser_tx), .irq(irq),
  .ien(ien_q), .rx_empty(rx_empty), .rx_read(rx_pop), .rx_push(rx_push),
  .tx_cnt(tx_cnt), .rx_cnt(rx_cnt)
);

// File: tb/test_uart_mmio.sv
module test_uart_mmio;
  localparam int DIVV = 3;
  localparam int BIT  = 16 * (DIVV + 1);

  logic        clk, rst_n, bus_wr, bus_rd, ser_rx, ser_tx, irq;
  logic [4:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  int          nchk, nerr;
  bit          done;

  uart_mmio i_uart_mmio (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .ser_tx(ser_tx), .ser_rx(ser_rx), .irq(irq)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic send(input logic [7:0] b, input bit good_stop);
    @(negedge clk);
    ser_rx = 1'b0;
    repeat (BIT) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      ser_rx = b[i];
      repeat (BIT) @(negedge clk);
    end
    if (!good_stop) begin
      ser_rx = 1'b0;
      repeat (40) @(negedge clk);
    end
    ser_rx = 1'b1;
    repeat (BIT) @(negedge clk);
  endtask

  task automatic capture(output logic [7:0] b, output bit ok, output logic stp);
    ok = 1'b0; b = '0; stp = 1'b0;
    for (int n = 0; n < 3000; n++) begin
      @(negedge clk);
      if (!ser_tx) begin ok = 1'b1; break; end
    end
    if (ok) begin
      repeat (BIT / 2) @(negedge clk);
      for (int i = 0; i < 8; i++) begin
        repeat (BIT) @(negedge clk);
        b[i] = ser_tx;
      end
      repeat (BIT) @(negedge clk);
      stp = ser_tx;
    end
  endtask

  task automatic t_reset;
    logic [31:0] d;
    check("R1 ser_tx", {31'b0, ser_tx}, 32'h1);
    check("R1 irq", {31'b0, irq}, 32'h0);
    rd(5'h08, d); check("R1 txctl", d, 32'h0);
    rd(5'h0C, d); check("R1 rxctl", d, 32'h0);
    rd(5'h10, d); check("R1 ien", d, 32'h0);
    rd(5'h18, d); check("R1 div", d, 32'h0);
    rd(5'h00, d); check("R1 txdata", d, 32'h0);
    rd(5'h04, d); check("R1 rxdata", d, 32'h8000_0000);
  endtask

  task automatic t_regs;
    logic [31:0] d;
    wr(5'h08, 32'hFFFF_FFFF); rd(5'h08, d); check("R2 txctl", d, 32'h1);
    wr(5'h0C, 32'hFFFF_FFFF); rd(5'h0C, d); check("R2 rxctl", d, 32'h1);
    wr(5'h10, 32'hFFFF_FFFF); rd(5'h10, d); check("R2 ien", d, 32'h3);
    wr(5'h18, 32'h1234_5678); rd(5'h18, d); check("R2 div", d, 32'h1234_5678);
    wr(5'h08, 0); wr(5'h0C, 0); wr(5'h10, 0);
    wr(5'h18, DIVV);
  endtask

  task automatic t_tx_frame;
    logic [7:0] b; bit ok; logic s;
    wr(5'h08, 1);
    wr(5'h00, 32'hFFFF_F1A5);
    capture(b, ok, s);
    check("R3 frame seen", {31'b0, ok}, 32'h1);
    check("R3 data A5", {24'b0, b}, 32'hA5);
    check("R3 stop high", {31'b0, s}, 32'h1);
  endtask

  task automatic t_tx_full;
    logic [31:0] d; logic [7:0] b; bit ok; logic s; bit low;
    repeat (BIT * 2) @(negedge clk);
    wr(5'h08, 0);
    for (int i = 0; i < 9; i++) wr(5'h00, 32'h10 + i);
    rd(5'h00, d); check("R4 full flag", d, 32'h8000_0000);
    low = 1'b0;
    for (int n = 0; n < 2 * BIT; n++) begin
      @(negedge clk);
      if (!ser_tx) low = 1'b1;
    end
    check("R5 line high while disabled", {31'b0, low}, 32'h0);
    wr(5'h08, 1);
    for (int i = 0; i < 8; i++) begin
      capture(b, ok, s);
      check("R4 queued byte order", {23'b0, ok, b}, {23'b0, 1'b1, 8'(8'h10 + i)});
    end
    low = 1'b0;
    for (int n = 0; n < 1500; n++) begin
      @(negedge clk);
      if (!ser_tx) low = 1'b1;
    end
    check("R4 ninth write dropped", {31'b0, low}, 32'h0);
    rd(5'h00, d); check("R4 not full after drain", d, 32'h0);
  endtask

  task automatic t_rx_off;
    logic [31:0] d;
    wr(5'h0C, 0);
    send(8'h5C, 1'b1);
    rd(5'h04, d); check("R8 disabled rx ignored", d, 32'h8000_0000);
  endtask

  task automatic t_rx_basic;
    logic [31:0] d;
    wr(5'h0C, 1);
    send(8'h3C, 1'b1);
    rd(5'h14, d); check("R9 pending set", d, 32'h2);
    check("R9 irq masked", {31'b0, irq}, 32'h0);
    wr(5'h10, 2);
    @(negedge clk); check("R9 irq raised", {31'b0, irq}, 32'h1);
    rd(5'h04, d); check("R6 byte read", d, 32'h3C);
    rd(5'h04, d); check("R7 empty read", d, 32'h8000_0000);
    rd(5'h04, d); check("R7 empty read again", d, 32'h8000_0000);
    rd(5'h14, d); check("R9 pending clear", d, 32'h0);
    check("R9 irq cleared", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_rx_overflow;
    logic [31:0] d;
    for (int i = 0; i < 9; i++) send(8'h40 + 8'(i), 1'b1);
    for (int i = 0; i < 8; i++) begin
      rd(5'h04, d); check("R10 stored order", d, 32'h40 + i);
    end
    rd(5'h04, d); check("R10 ninth dropped", d, 32'h8000_0000);
  endtask

  task automatic t_frame_err;
    logic [31:0] d;
    send(8'h77, 1'b0);
    rd(5'h04, d); check("R11 bad stop dropped", d, 32'h8000_0000);
    send(8'h66, 1'b1);
    rd(5'h04, d); check("R11 next frame kept", d, 32'h66);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nerr++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
    end
  end

  initial begin
    nchk = 0; nerr = 0; done = 1'b0;
    rst_n = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0; bus_addr = '0; bus_wdata = '0;
    ser_rx = 1'b1;
    repeat (5) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_regs();
    t_tx_frame();
    t_tx_full();
    t_rx_off();
    t_rx_basic();
    t_rx_overflow();
    t_frame_err();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule